// File: doc/BRIEF.md
# Interrupt-Driven I2C Host Controller

This block is the host side of a two-wire control link to a slave processor. It drives an open-drain clock line and an open-drain data line, shifts command bytes out and response bytes in, and frames each transaction with start and stop conditions. The slave's 7-bit bus address is fixed at zero. A write begins with address byte 0x00, and a read begins with address byte 0x01.

Writes come from a simple byte interface. The host logic presents a byte with a last marker, and the block asks for each byte when it needs it. Reads are never requested by the host logic. They begin on their own when the slave pulls its active-low interrupt line low. Each received byte appears on a one-cycle valid strobe. When a byte gets no acknowledge, the block sends it once more. If the second attempt also fails, the block ends the transaction, latches an error flag and holds a reset output to the slave for a fixed number of cycles.

Top module: `i2c_irq_host`

## Requirements
- R1: A transaction opens with a start: the data line goes low while the clock line has been released (high) and stays high for two more quarter periods. `busy` is high from the cycle after the request until the transaction has fully ended.
- R2: Every transaction, including an aborted one, ends with a stop: the data line rises while the clock line is high. After the stop both lines are released and `busy` falls. Exactly one start and one stop are seen per transaction.
- R3: Every byte goes out most significant bit first. The first byte after a start is 0x00 (slave address zero, R/W bit 0) for a write and 0x01 (R/W bit 1) for a read.
- R4: After each byte the block sends, it releases the data line for a ninth clock and samples it near the end of that clock's high phase. A low level is an acknowledge.
- R5: A byte that is not acknowledged is sent again once, with no new start. If the resend is acknowledged, the transaction goes on normally. This applies to the address byte as well.
- R6: If the resend is also not acknowledged, the block sends a stop, sets `err`, requests no more command bytes, and drives `dev_rst` high for exactly RST_CYC cycles. `busy` stays high until that window is over. `err` stays set until the next transaction starts, which clears it.
- R7: In idle, a low `irq_n` starts a read. When `irq_n` is low and `cmd_valid` is high in the same cycle, the read goes first and the write follows it.
- R8: During a read, each received byte is reported on `rd_data` with a one-cycle `rd_valid` pulse. The block acknowledges a byte if `irq_n` is still low at the start of its ninth clock. Otherwise it sends no acknowledge and then a stop.
- R9: Every clock high phase inside a byte lasts 2*QTR_CYC system cycles. While the clock is high inside a byte, the block never changes the data line.
- R10: Both lines are open-drain: `scl_oe`/`sda_oe` high means "drive low". In idle both are low, so both lines are released.
- R11: `cmd_ready` is high only while a transaction is busy and the next command byte is needed. A write ends after the byte marked `cmd_last` has been acknowledged.
- R12: After reset the block is idle: `busy`, `err`, `dev_rst`, `cmd_ready`, `rd_valid`, `scl_oe` and `sda_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Slave's active-low data-ready request |
| cmd_valid | input | 1 | A command byte is offered |
| cmd_data | input | 8 | Command byte to send |
| cmd_last | input | 1 | Offered byte is the final one of the write |
| cmd_ready | output | 1 | Command byte taken at this edge when valid |
| rd_valid | output | 1 | One-cycle strobe for a received byte |
| rd_data | output | 8 | Received byte |
| busy | output | 1 | Transaction or slave reset window in progress |
| err | output | 1 | Resend failed in the last transaction |
| dev_rst | output | 1 | Active-high reset request to the slave |
| scl_oe | output | 1 | Pull the clock line low |
| sda_i | input | 1 | Data line level as seen on the bus |
| sda_oe | output | 1 | Pull the data line low |

## Verification
The bench builds the block with QTR_CYC=2 and RST_CYC=5. With these values a byte takes only 72 system cycles, so the bench can sweep writes and reads of one to four bytes, fault on single and double missing acknowledges for address and data bytes, and collide a read with a pending write, all in a short run. The short reset window lets the bench count the `dev_rst` width cycle by cycle. The 4-cycle clock high phase can be measured exactly at every rising and falling clock edge.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BIT, S_ACK, S_LOAD, S_STOP, S_RST
  } host_st_t;

  // first byte of a transaction: zero slave address plus direction bit
  function automatic logic [7:0] addr_byte(input logic rd);
    return {7'b0000000, rd};
  endfunction

  // bit index 0 is the first bit on the wire (the MSB)
  function automatic logic wire_bit(input logic [7:0] b, input logic [2:0] idx);
    return b[3'd7 - idx];
  endfunction

endpackage

// File: rtl/i2c_qtr_tick.sv
module i2c_qtr_tick #(
  parameter int QTR_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = !hold && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || hold || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_rst_timer.sv
module i2c_rst_timer #(
  parameter int RST_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic [CW-1:0] cnt;

  assign active = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (fire)   cnt <= CW'(RST_CYC);
    else if (active) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/i2c_irq_host.sv
module i2c_irq_host
  import i2c_irq_pkg::*;
#(
  parameter int QTR_CYC = 25,
  parameter int RST_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_data,
  input  logic       cmd_last,
  output logic       cmd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       err,
  output logic       dev_rst,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);

  host_st_t   st;
  logic [1:0] q;          // quarter inside the current bit slot
  logic [2:0] bcnt;       // bit index inside the byte, wire order
  logic [7:0] tx_byte;
  logic [7:0] rx_sh;
  logic       rd_mode, at_addr, last_tx, retried, rx_last, abort;
  logic       sda_low_r, rd_valid_r, err_r;
  logic [7:0] rd_data_r;

  // named internal events
  logic tick, qend, tx_phase, hold;
  logic in_data_slot, in_start, in_stop;
  logic nack_evt, fail_evt, rst_fire, rst_active;

  assign hold         = (st == S_IDLE) || (st == S_LOAD) || (st == S_RST);
  assign qend         = tick && (q == 2'd3);
  assign tx_phase     = !rd_mode || at_addr;
  assign in_data_slot = (st == S_BIT) || (st == S_ACK);
  assign in_start     = (st == S_START);
  assign in_stop      = (st == S_STOP);
  assign nack_evt     = qend && (st == S_ACK) && tx_phase && sda_i;
  assign fail_evt     = nack_evt && retried;
  assign rst_fire     = qend && in_stop && abort;

  i2c_qtr_tick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick)
  );

  i2c_rst_timer #(.RST_CYC(RST_CYC)) u_rtim (
    .clk(clk), .rst_n(rst_n), .fire(rst_fire), .active(rst_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  q <= '0;  bcnt <= '0;
      tx_byte <= '0; rx_sh <= '0; rd_data_r <= '0;
      rd_mode <= 1'b0; at_addr <= 1'b0; last_tx <= 1'b0; retried <= 1'b0;
      rx_last <= 1'b0; abort <= 1'b0; sda_low_r <= 1'b0;
      rd_valid_r <= 1'b0; err_r <= 1'b0;
    end else begin
      rd_valid_r <= 1'b0;
      if (tick) q <= q + 2'd1;
      case (st)
        S_IDLE: begin
          if (!irq_n || cmd_valid) begin
            rd_mode <= !irq_n;
            tx_byte <= addr_byte(!irq_n);
            st      <= S_START;
            q       <= '0;
            bcnt    <= '0;
            at_addr <= 1'b1;
            retried <= 1'b0;
            last_tx <= 1'b0;
            abort   <= 1'b0;
            err_r   <= 1'b0;
          end
        end
        S_START: begin
          if (tick && q == 2'd1) sda_low_r <= 1'b1;
          if (qend) st <= S_BIT;
        end
        S_BIT: begin
          if (tick && q == 2'd0)
            sda_low_r <= tx_phase ? !wire_bit(tx_byte, bcnt) : 1'b0;
          if (qend) begin
            if (!tx_phase) rx_sh <= {rx_sh[6:0], sda_i};
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              st <= S_ACK;
              if (!tx_phase) begin
                rd_valid_r <= 1'b1;
                rd_data_r  <= {rx_sh[6:0], sda_i};
              end
            end
          end
        end
        S_ACK: begin
          if (tick && q == 2'd0) begin
            if (tx_phase) sda_low_r <= 1'b0;
            else begin
              sda_low_r <= !irq_n;
              rx_last   <= irq_n;
            end
          end
          if (qend) begin
            if (tx_phase) begin
              if (!sda_i) begin
                retried <= 1'b0;
                if (at_addr) begin
                  at_addr <= 1'b0;
                  st      <= rd_mode ? S_BIT : S_LOAD;
                end else begin
                  st <= last_tx ? S_STOP : S_LOAD;
                end
              end else if (!retried) begin
                retried <= 1'b1;
                st      <= S_BIT;
              end else begin
                err_r <= 1'b1;
                abort <= 1'b1;
                st    <= S_STOP;
              end
            end else begin
              st <= rx_last ? S_STOP : S_BIT;
            end
          end
        end
        S_LOAD: begin
          q <= '0;
          if (cmd_valid) begin
            tx_byte <= cmd_data;
            last_tx <= cmd_last;
            st      <= S_BIT;
          end
        end
        S_STOP: begin
          if (tick && q == 2'd0) sda_low_r <= 1'b1;
          if (tick && q == 2'd2) sda_low_r <= 1'b0;
          if (qend) st <= abort ? S_RST : S_IDLE;
        end
        S_RST: begin
          if (!rst_active) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scl_oe    = (st == S_LOAD) ||
                     ((in_data_slot || in_stop) && !q[1]);
  assign sda_oe    = sda_low_r;
  assign busy      = (st != S_IDLE);
  assign cmd_ready = (st == S_LOAD);
  assign rd_valid  = rd_valid_r;
  assign rd_data   = rd_data_r;
  assign err       = err_r;
  assign dev_rst   = rst_active;

endmodule

// File: rtl/i2c_irq_host_chk.sv
module i2c_irq_host_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic cmd_ready,
  input logic err,
  input logic dev_rst,
  input logic scl_oe,
  input logic sda_oe,
  input logic rd_valid,
  input logic in_data_slot,
  input logic in_start,
  input logic in_stop,
  input logic nack_evt,
  input logic fail_evt,
  input logic retried
);

  p_start_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && in_start) |-> !scl_oe);

  p_retry_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_evt && !retried) |=> (in_data_slot && retried));

  p_fail_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> in_stop);

  p_rst_has_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst) |-> err);

  p_rdv_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_sda_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data_slot && $past(in_data_slot) && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe));

  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> busy);

endmodule

bind i2c_irq_host i2c_irq_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_ready(cmd_ready),
  .err(err), .dev_rst(dev_rst), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .rd_valid(rd_valid), .in_data_slot(in_data_slot), .in_start(in_start),
  .in_stop(in_stop), .nack_evt(nack_evt), .fail_evt(fail_evt),
  .retried(retried)
);

// File: tb/sim_i2c_irq_host.sv
`timescale 1ns/1ps
module sim_i2c_irq_host;
  localparam int QTR = 2;
  localparam int RSTC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic cmd_last = 1'b0;
  logic cmd_ready, rd_valid, busy, err, dev_rst, scl_oe, sda_oe, sda_i, irq_n;
  logic [7:0] rd_data;

  // slave model state
  logic s_low = 1'b0;
  int arm_seq = 0, done_seq = 0, kill_seq = 0;
  int rd_n = 1, nack_at = -1, nack_total = 0;

  assign sda_i = !(sda_oe || s_low);
  assign irq_n = !((arm_seq != done_seq) && (arm_seq != kill_seq));

  always #2.5 clk = ~clk;

  i2c_irq_host #(.QTR_CYC(QTR), .RST_CYC(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_last(cmd_last), .cmd_ready(cmd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .err(err),
    .dev_rst(dev_rst), .scl_oe(scl_oe), .sda_i(sda_i), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] wr_pat(input int i);
    return 8'(8'hC3 + i * 8'h47);
  endfunction
  function automatic logic [7:0] rd_pat(input int i);
    return 8'(i * 29) ^ 8'h5A;
  endfunction

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cumulative monitor results
  logic [7:0] mlog [0:255];
  int nlog = 0, starts = 0, stops = 0, rd_cnt = 0, rd_bad = 0;
  int macks = 0, mnacks = 0, hi_bad = 0, ack9_bad = 0, rst_len = 0;
  int mode = 3, sbit = 0, bidx = 0, rbi = 0, hi_len = 0, nack_used = 0;
  bit p_scl = 1, p_sda = 1, sacked = 0, mack = 0, fall_ok = 0;

  always @(negedge clk) begin
    bit scl_now, sda_now;
    logic [7:0] pb;
    scl_now = !scl_oe;
    sda_now = sda_i;
    if (rst_n) begin
      if (scl_now && p_scl && p_sda && !sda_now) begin
        starts++; mode = 0; sbit = 0; bidx = 0; nack_used = 0;
        s_low = 0; fall_ok = 0;
      end else if (scl_now && p_scl && !p_sda && sda_now) begin
        stops++; mode = 3; s_low = 0; fall_ok = 0;
      end else if (scl_now && !p_scl) begin
        if (mode != 3) begin
          if (sbit < 8 && mode != 2) pb = 8'h00;
          if (sbit < 8 && mode != 2) mlog[nlog[7:0]] = mlog[nlog[7:0]];
          if (sbit == 8 && mode != 2 && sda_oe) ack9_bad++;
          if (sbit == 8 && mode == 2) begin
            mack = !sda_now;
            if (mack) macks++; else mnacks++;
          end
          sbit++;
        end
      end else if (!scl_now && p_scl) begin
        if (fall_ok && hi_len != 2 * QTR) hi_bad++;
        fall_ok = 1;
        if (mode != 3) begin
          if (sbit == 8) begin
            if (mode != 2) begin
              mlog[nlog[7:0]] = sr;
              nlog++;
              if (bidx == nack_at && nack_used < nack_total) begin
                nack_used++; sacked = 0; s_low = 0;
              end else begin
                sacked = 1; s_low = 1;
              end
            end else s_low = 0;
          end else if (sbit == 9) begin
            sbit = 0; s_low = 0;
            if (mode == 2) begin
              if (mack) begin
                rbi++; pb = rd_pat(rbi); s_low = !pb[7];
                if (rbi == rd_n - 1) done_seq = arm_seq;
              end else mode = 3;
            end else if (sacked) begin
              if (mode == 0) begin
                bidx = 1;
                if (sr[0]) begin
                  mode = 2; rbi = 0; pb = rd_pat(0); s_low = !pb[7];
                  if (rd_n == 1) done_seq = arm_seq;
                end else mode = 1;
              end else bidx++;
            end
          end else if (mode == 2 && sbit >= 1 && sbit <= 7) begin
            pb = rd_pat(rbi); s_low = !pb[7 - sbit];
          end
        end
      end
      if (scl_now && p_scl == 1'b0 && mode != 3 && sbit >= 1 && sbit <= 8
          && mode != 2)
        sr = {sr[6:0], sda_now};
      if (scl_now) hi_len++; else hi_len = 0;
      if (rd_valid) begin
        if (rd_data !== rd_pat(rd_cnt % 1000 - rd_base)) rd_bad++;
        rd_cnt++;
      end
      if (dev_rst) rst_len++;
    end
    p_scl = scl_now;
    p_sda = !(sda_oe || s_low);
  end

  // shift register of the slave receiver and read-index base
  logic [7:0] sr = 8'h00;
  int rd_base = 0;

  // snapshots
  int b_nlog, b_starts, b_stops, b_rd, b_rdbad, b_mack, b_mnack, b_hi, b_a9, b_rst;

  task automatic snap();
    b_nlog = nlog; b_starts = starts; b_stops = stops; b_rd = rd_cnt;
    b_rdbad = rd_bad; b_mack = macks; b_mnack = mnacks; b_hi = hi_bad;
    b_a9 = ack9_bad; b_rst = rst_len;
  endtask

  task automatic do_write(input int n, input bit abort_ok, output int hs);
    int idx;
    bit seen;
    idx = 0; hs = 0; seen = 0;
    @(negedge clk);
    cmd_data = wr_pat(0); cmd_last = (n == 1); cmd_valid = 1'b1;
    while (idx < n) begin
      @(negedge clk);
      if (busy) seen = 1;
      else if (seen && abort_ok) break;
      if (cmd_ready) begin
        @(posedge clk); #1;
        idx++; hs++;
        cmd_data = wr_pat(idx); cmd_last = (idx == n - 1);
        if (idx == n) cmd_valid = 1'b0;
      end
    end
    cmd_valid = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_read(input int n);
    rd_n = n;
    rd_base = rd_cnt;
    @(negedge clk);
    arm_seq++;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    kill_seq = arm_seq;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int hs;
    repeat (4) @(negedge clk);
    // R12: reset state
    chk("R12 busy", busy, 0);
    chk("R12 err", err, 0);
    chk("R12 dev_rst", dev_rst, 0);
    chk("R12 cmd_ready", cmd_ready, 0);
    chk("R12 rd_valid", rd_valid, 0);
    chk("R10 lines released in reset", scl_oe | sda_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // write sweep
    for (int n = 1; n <= 4; n++) begin
      nack_total = 0; nack_at = -1;
      snap();
      do_write(n, 0, hs);
      chk("R1 one start per write", starts - b_starts, 1);
      chk("R2 one stop per write", stops - b_stops, 1);
      chk("R11 bytes requested", hs, n);
      chk("R3 byte count on bus", nlog - b_nlog, n + 1);
      chk("R3 write address byte", mlog[b_nlog[7:0]], 8'h00);
      for (int i = 0; i < n; i++)
        chk("R3 data byte msb first", mlog[8'(b_nlog + 1 + i)], wr_pat(i));
      chk("R9 high phase width", hi_bad - b_hi, 0);
      chk("R4 released on ninth clock", ack9_bad - b_a9, 0);
      chk("R6 no error on clean write", err, 0);
      chk("R10 idle released", scl_oe | sda_oe, 0);
    end

    // read sweep
    for (int n = 1; n <= 4; n++) begin
      nack_total = 0; nack_at = -1;
      snap();
      do_read(n);
      chk("R7 read address byte", mlog[b_nlog[7:0]], 8'h01);
      chk("R8 bytes returned", rd_cnt - b_rd, n);
      chk("R8 returned data", rd_bad - b_rdbad, 0);
      chk("R8 master acks", macks - b_mack, n - 1);
      chk("R8 final no-ack", mnacks - b_mnack, 1);
      chk("R2 stop after read", stops - b_stops, 1);
      chk("R9 high phase width read", hi_bad - b_hi, 0);
    end

    // R5: data byte missed once then resent
    nack_at = 2; nack_total = 1;
    snap();
    do_write(3, 0, hs);
    chk("R5 bus bytes with resend", nlog - b_nlog, 5);
    chk("R5 resent byte", mlog[8'(b_nlog + 3)], wr_pat(1));
    chk("R5 byte after resend", mlog[8'(b_nlog + 4)], wr_pat(2));
    chk("R5 single start", starts - b_starts, 1);
    chk("R4 no error after good resend", err, 0);

    // R6: data byte missed twice
    nack_at = 1; nack_total = 2;
    snap();
    do_write(3, 1, hs);
    chk("R6 bytes requested before abort", hs, 1);
    chk("R6 bus bytes", nlog - b_nlog, 3);
    chk("R6 stop on abort", stops - b_stops, 1);
    chk("R6 err latched", err, 1);
    chk("R6 reset width", rst_len - b_rst, RSTC);

    // R6: err cleared by next transaction
    nack_at = -1; nack_total = 0;
    do_write(1, 0, hs);
    chk("R6 err cleared on new start", err, 0);

    // R5: read address missed once
    nack_at = 0; nack_total = 1;
    snap();
    do_read(2);
    chk("R5 address resent", mlog[8'(b_nlog + 1)], 8'h01);
    chk("R5 read after resend", rd_cnt - b_rd, 2);
    chk("R5 read data after resend", rd_bad - b_rdbad, 0);

    // R6: read address missed twice
    nack_at = 0; nack_total = 2;
    snap();
    do_read(1);
    chk("R6 no bytes on aborted read", rd_cnt - b_rd, 0);
    chk("R6 err on aborted read", err, 1);
    chk("R6 reset width read", rst_len - b_rst, RSTC);

    // R7: interrupt and command together, read first
    nack_at = -1; nack_total = 0;
    snap();
    rd_n = 1; rd_base = rd_cnt;
    arm_seq++;
    do_write(2, 0, hs);
    kill_seq = arm_seq;
    chk("R7 read goes first", mlog[b_nlog[7:0]], 8'h01);
    chk("R7 write follows", mlog[8'(b_nlog + 1)], 8'h00);
    chk("R7 write data", mlog[8'(b_nlog + 3)], wr_pat(1));
    chk("R7 both transactions", starts - b_starts, 2);
    chk("R8 read during collision", rd_cnt - b_rd, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule